// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit sits beside the command engine of a serial nonvolatile memory. It holds the 8-bit status byte that a status-read command shifts out. It also decides, for every memory byte the engine is about to store, whether that store is allowed. The engine passes decoded events to the unit: write-enable, write-disable, the start of a status-write data phase, a complete status-write data byte, and the chip-select rise that ends a recognised memory-write or status-write. The unit also takes the level of the hardware write-protect pin and the address of the byte being stored.

The stored bits are, from most to least significant: a pin-protect enable, three spare bits that software may store and read back, a two-bit region selector, the write-enable latch, and a constant zero. The upper bits are nonvolatile in the finished device. Here they are ordinary flip-flops that load a parameterised value at reset. A memory store is allowed only when the write-enable latch is set and the address lies outside the region picked by the selector. A status store is allowed when the latch is set, except when the pin-protect enable is 1 and the pin was low at the start of the data phase.

Top module: `sr_protect_unit`

## Requirements
- R1: After reset the status byte reads 0x00 with the default parameters, and the write-enable latch (bit 1) is clear.
- R2: A write-enable event sets bit 1 on the next clock edge and a write-disable event clears it. When both arrive in the same cycle, the latch ends clear.
- R3: An end-of-write event (chip-select rise after a recognised memory or status write) clears bit 1 on the next clock edge, and takes priority over a write-enable in the same cycle.
- R4: Bit 0 always reads 0. A status store discards data bits 1 and 0, so bit 1 keeps the latch value.
- R5: An allowed status store copies data bits 7 to 2 into the status byte (bit 7 pin-protect enable, bits 6 to 4 spare, bits 3 to 2 region selector) on the next clock edge.
- R6: A status store is refused, leaving bits 7 to 2 unchanged, when bit 1 is clear, or when bit 7 is 1 and the captured pin level is 0.
- R7: The pin level is captured in the cycle that marks the start of the status-write data phase. Pin changes after that have no effect on the same command.
- R8: The memory-write permit is 0 whenever bit 1 is clear.
- R9: With bit 1 set, the region selector (bits 3:2) protects these ranges of the 18-bit address, and the permit is 0 inside them: 00 none, 01 0x30000 to 0x3FFFF, 10 0x20000 to 0x3FFFF, 11 every address.
- R10: A data phase that starts but never delivers a complete byte leaves the whole status byte unchanged, the latch included.
- R11: A complete status byte and an end-of-write event in the same cycle both take effect. The new bits 7 to 2 are stored and the latch clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wren_i | input | 1 | Write-enable event pulse |
| wrdi_i | input | 1 | Write-disable event pulse |
| sw_start_i | input | 1 | Start of status-write data phase (pin capture) |
| sw_commit_i | input | 1 | Complete status data byte received with chip select low |
| sw_data_i | input | 8 | Status data byte |
| wr_end_i | input | 1 | Chip-select rise ending a recognised write command |
| wp_i | input | 1 | Hardware write-protect pin level |
| mem_addr_i | input | ADDR_W | Address of the memory byte to be stored |
| status_o | output | 8 | Status byte for reads |
| mem_permit_o | output | 1 | Store of the addressed byte allowed |

## Verification
A status-byte commit and the end-of-write clear can arrive in the same cycle when the last data bit and the chip-select rise are reported together. The bench drives both in one vector. It expects the new protection bits and a cleared latch. Two more collisions are driven in single cycles: write-enable against write-disable, and the data-phase start against its commit. The expected status byte and permit for each are worked out by hand from the requirements.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef struct packed {
        logic       pin_lock;   // bit 7
        logic [2:0] spare;      // bits 6..4
        logic [1:0] region;     // bits 3..2
        logic       wel;        // bit 1
        logic       zero;       // bit 0
    } sr_byte_t;

    typedef struct packed {
        logic       pin_lock;
        logic [2:0] spare;
        logic [1:0] region;
    } sr_nv_t;

    localparam int unsigned SR_W = 8;

    function automatic sr_nv_t sr_nv_from_byte(input logic [SR_W-1:0] b);
        sr_nv_t r;
        r.pin_lock = b[7];
        r.spare    = b[6:4];
        r.region   = b[3:2];
        return r;
    endfunction

endpackage

// File: rtl/sr_wel_ctrl.sv
module sr_wel_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic end_i,
    output logic wel_o
);
    typedef struct packed {
        logic wel;
    } wel_state_t;

    wel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)
            st_d.wel = 1'b1;
        if (clr_i || end_i)
            st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wel_o = st_q.wel;
endmodule

// File: rtl/sr_nv_bank.sv
module sr_nv_bank
    import sr_pkg::*;
#(
    parameter logic [7:0] NV_RESET = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_i,
    input  logic       start_i,
    input  logic       commit_i,
    input  logic [7:0] data_i,
    input  logic       wp_i,
    output sr_nv_t     nv_o
);
    typedef struct packed {
        sr_nv_t nv;
        logic   wp_cap;
    } nv_state_t;

    localparam sr_nv_t NV_INIT = sr_nv_from_byte(NV_RESET);

    nv_state_t st_d, st_q;
    logic      wp_eff;
    logic      allow;

    always_comb begin
        st_d   = st_q;
        wp_eff = start_i ? wp_i : st_q.wp_cap;
        allow  = wel_i && !(st_q.nv.pin_lock && !wp_eff);
        if (start_i)
            st_d.wp_cap = wp_i;
        if (commit_i && allow)
            st_d.nv = sr_nv_from_byte(data_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.nv     <= NV_INIT;
            st_q.wp_cap <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign nv_o = st_q.nv;
endmodule

// File: rtl/sr_region_check.sv
module sr_region_check #(
    parameter int unsigned ADDR_W = 18
) (
    input  logic [1:0]        region_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int unsigned TOP_W = 2;

    logic [TOP_W-1:0] top_bits;
    logic [3:0]       code_hit;

    assign top_bits = addr_i[ADDR_W-1 -: TOP_W];

    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_code
            if (g == 0) begin : g_none
                assign code_hit[g] = 1'b0;
            end else if (g == 1) begin : g_quarter
                assign code_hit[g] = (top_bits == 2'b11);
            end else if (g == 2) begin : g_half
                assign code_hit[g] = top_bits[1];
            end else begin : g_all
                assign code_hit[g] = 1'b1;
            end
        end
    endgenerate

    assign hit_o = code_hit[region_i];
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
    import sr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 18,
    parameter logic [7:0]  NV_RESET = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              sw_start_i,
    input  logic              sw_commit_i,
    input  logic [7:0]        sw_data_i,
    input  logic              wr_end_i,
    input  logic              wp_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    output logic [7:0]        status_o,
    output logic              mem_permit_o
);
    logic     wel;
    sr_nv_t   nv;
    logic     in_region;
    sr_byte_t sbyte;

    sr_wel_ctrl u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wren_i),
        .clr_i (wrdi_i),
        .end_i (wr_end_i),
        .wel_o (wel)
    );

    sr_nv_bank #(.NV_RESET(NV_RESET)) u_nv (
        .clk      (clk),
        .rst_n    (rst_n),
        .wel_i    (wel),
        .start_i  (sw_start_i),
        .commit_i (sw_commit_i),
        .data_i   (sw_data_i),
        .wp_i     (wp_i),
        .nv_o     (nv)
    );

    sr_region_check #(.ADDR_W(ADDR_W)) u_region (
        .region_i (nv.region),
        .addr_i   (mem_addr_i),
        .hit_o    (in_region)
    );

    always_comb begin
        sbyte.pin_lock = nv.pin_lock;
        sbyte.spare    = nv.spare;
        sbyte.region   = nv.region;
        sbyte.wel      = wel;
        sbyte.zero     = 1'b0;
    end

    assign status_o     = sbyte;
    assign mem_permit_o = wel && !in_region;
endmodule

// File: rtl/sr_protect_checker.sv
module sr_protect_checker #(
    parameter int unsigned ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wren_i,
    input logic              wrdi_i,
    input logic              sw_commit_i,
    input logic              wr_end_i,
    input logic [ADDR_W-1:0] mem_addr_i,
    input logic [7:0]        status_o,
    input logic              mem_permit_o
);
    assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_i && !wrdi_i && !wr_end_i) |=> status_o[1]);

    assert_wel_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrdi_i |=> !status_o[1]);

    assert_end_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end_i |=> !status_o[1]);

    assert_no_wel_no_permit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> !mem_permit_o);

    assert_all_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11) |-> !mem_permit_o);

    assert_upper_quarter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] != 2'b00 && mem_addr_i[ADDR_W-1 -: 2] == 2'b11) |-> !mem_permit_o);

    assert_no_commit_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_commit_i |=> $stable(status_o[7:2]));

    assert_refused_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_commit_i && !status_o[1]) |=> $stable(status_o[7:2]));
endmodule

bind sr_protect_unit sr_protect_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wren_i       (wren_i),
    .wrdi_i       (wrdi_i),
    .sw_commit_i  (sw_commit_i),
    .wr_end_i     (wr_end_i),
    .mem_addr_i   (mem_addr_i),
    .status_o     (status_o),
    .mem_permit_o (mem_permit_o)
);

// File: tb/sim_sr_protect_unit.sv
`timescale 1ns/1ps
module sim_sr_protect_unit;
    localparam int ADDR_W = 18;
    localparam int NVEC   = 22;

    typedef struct packed {
        logic        wren;
        logic        wrdi;
        logic        start;
        logic        commit;
        logic        wend;
        logic        wp;
        logic [7:0]  data;
        logic [17:0] addr;
        logic [7:0]  exp_st;
        logic        exp_perm;
    } vec_t;

    // exp_st / exp_perm: state seen after the clock edge that takes the vector
    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,18'h00000,8'h00,1'b0}, // R8 idle
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,18'h00000,8'h02,1'b1}, // R2 set
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h00,18'h3FFFF,8'h02,1'b1}, // R7 capture 1
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,8'hFF,18'h00000,8'hFC,1'b0}, // R11 R4
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,18'h00000,8'hFE,1'b0}, // R9 all
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,18'h00000,8'hFE,1'b0}, // R7 capture 0
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h00,18'h00000,8'hFE,1'b0}, // R6 R7 refused
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h00,18'h00000,8'hFE,1'b0}, // capture 1
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h84,18'h2FFFF,8'h86,1'b1}, // R5 R9 quarter
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,18'h30000,8'h86,1'b0}, // R9 quarter in
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h00,18'h30000,8'h86,1'b0}, // capture 1
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h0B,18'h1FFFF,8'h0A,1'b1}, // R4 R9 half
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,18'h20000,8'h0A,1'b0}, // R9 half in
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,18'h00000,8'h08,1'b0}, // R2 clear
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,8'h00,18'h00000,8'h08,1'b0}, // R6 no latch
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,18'h00000,8'h08,1'b0}, // R2 both
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,18'h10000,8'h0A,1'b1}, // R2 set
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h00,18'h10000,8'h08,1'b0}, // R3 end
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,18'h00000,8'h0A,1'b1}, // set
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,18'h00000,8'h0A,1'b1}, // R10 start
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,18'h00000,8'h0A,1'b1}, // R10 short byte
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h70,18'h3FFFF,8'h72,1'b1}  // R5 spare
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wren_i = 1'b0, wrdi_i = 1'b0, sw_start_i = 1'b0;
    logic              sw_commit_i = 1'b0, wr_end_i = 1'b0, wp_i = 1'b1;
    logic [7:0]        sw_data_i = '0;
    logic [ADDR_W-1:0] mem_addr_i = '0;
    logic [7:0]        status_o;
    logic              mem_permit_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sr_protect_unit #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
        .sw_start_i(sw_start_i), .sw_commit_i(sw_commit_i), .sw_data_i(sw_data_i),
        .wr_end_i(wr_end_i), .wp_i(wp_i), .mem_addr_i(mem_addr_i),
        .status_o(status_o), .mem_permit_o(mem_permit_o)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic quiet();
        wren_i = 0; wrdi_i = 0; sw_start_i = 0; sw_commit_i = 0; wr_end_i = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check8("R1 reset status", status_o, 8'h00);
        check1("R1 R8 reset permit", mem_permit_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            wren_i = VEC[i].wren; wrdi_i = VEC[i].wrdi;
            sw_start_i = VEC[i].start; sw_commit_i = VEC[i].commit;
            wr_end_i = VEC[i].wend; wp_i = VEC[i].wp;
            sw_data_i = VEC[i].data; mem_addr_i = VEC[i].addr;
            @(posedge clk);
            #1;
            check8($sformatf("vector %0d status", i), status_o, VEC[i].exp_st);
            check1($sformatf("vector %0d permit", i), mem_permit_o, VEC[i].exp_perm);
            @(negedge clk);
            quiet();
        end
        // R9 sweep of region boundaries with spare bits 0x72 -> set region 01 first
        wren_i = 1; @(negedge clk); quiet();
        sw_start_i = 1; wp_i = 1; @(negedge clk); quiet();
        sw_commit_i = 1; sw_data_i = 8'h04; @(negedge clk); quiet();
        check8("R5 region 01 stored", status_o, 8'h06);
        mem_addr_i = 18'h2FFFF; #1; check1("R9 below quarter", mem_permit_o, 1'b1);
        mem_addr_i = 18'h30000; #1; check1("R9 quarter start", mem_permit_o, 1'b0);
        mem_addr_i = 18'h3FFFF; #1; check1("R9 quarter end", mem_permit_o, 1'b0);
        // R3 end event beats write-enable in the same cycle
        @(negedge clk);
        wren_i = 1; wr_end_i = 1; @(negedge clk); quiet();
        check8("R3 end over enable", status_o, 8'h04);
        // R1 mid-run reset
        rst_n = 0; @(negedge clk);
        check8("R1 reset again", status_o, 8'h00);
        rst_n = 1; @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule